// File: doc/BRIEF.md
# Cluster Core Barrier Synchroniser

This block lets the cores of one cluster meet at a common point before any of them goes on. The cluster is built from sockets, and each socket holds a fixed number of cores. The unit keeps several independent barriers. Each barrier is a register with one bit per core in the cluster. A core that reaches a barrier sends one arrival request. The request carries the barrier number, the number of participants the software expects and the core's global identifier. The core then stays suspended until the unit tells it to resume.

Each arrival records the core's bit in the selected barrier. The unit counts the set bits, including the bit written by that arrival. When the count equals the participant number carried on the request, the unit sends a one-cycle resume pulse to every core whose bit is set. In the same step it clears the barrier so that it can be used again. The resume vector is flat: bit `s*CORES_PER_SOCKET + c` wakes core `c` of socket `s`. A participant number that can never be reached raises an error pulse for that arrival.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset, `resume_o` and `arr_err` are 0 and every barrier mask is empty. A later arrival with count 1 therefore wakes only the arriving core.
- R2: An arrival sets bit `arr_core_id % NUM_CORES` of the barrier selected by `arr_bar_id` (default `NUM_CORES` = 8, so id 9 sets bit 1).
- R3: While the number of set bits in a barrier is below the request's count, no resume is issued for that barrier.
- R4: When an accepted arrival makes the number of set bits (its own bit included) equal `arr_count`, `resume_o` equals that mask in the cycle after acceptance.
- R5: Resume bit `i` addresses socket `i / CORES_PER_SOCKET`, core `i % CORES_PER_SOCKET`. With the defaults, bit 5 is socket 1, core 1.
- R6: A release clears the barrier's mask. A following arrival on the same barrier starts from an empty mask.
- R7: Barriers are independent. Arrivals on one barrier neither change nor release another.
- R8: A repeated arrival from a core whose bit is already set does not raise the number of set bits.
- R9: An arrival with `arr_count` equal to 0 or greater than `NUM_CORES` raises `arr_err` for one cycle, in the cycle after acceptance, and releases nothing. The core's bit is still recorded.
- R10: `arr_ready` is 1 in every cycle after the reset synchroniser releases. At most one arrival is accepted per cycle.
- R11: Each resume is a pulse. Unless another release follows at once, `resume_o` returns to 0 one cycle after it was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| arr_valid | input | 1 | Arrival request valid |
| arr_ready | output | 1 | Arrival accepted when high together with `arr_valid` |
| arr_bar_id | input | BAR_W | Barrier number |
| arr_count | input | CNT_W | Expected participant count |
| arr_core_id | input | CORE_ID_W | Global core identifier |
| resume_o | output | NUM_CORES | One-cycle resume pulses, bit s*CORES_PER_SOCKET+c |
| arr_err | output | 1 | One-cycle pulse: the arrival's count can never be reached |

## Verification
The assertions check on every cycle that:
- a resume pulse always follows an accepted arrival;
- the pulse holds exactly as many bits as the count on that arrival;
- the pulse includes the arriving core's own bit;
- an error pulse follows only an out-of-range count and never comes with a resume;
- `arr_ready` stays high once it has risen.

Only the directed scenarios can show which cores a mask holds after a sequence of arrivals. That takes in the modulo mapping of core identifiers, duplicate arrivals and independence between barriers. The scenarios also show that a mask is cleared by release and that bits left behind by erroneous arrivals still count later.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bsu_rst_sync.sv
module bsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bsu_core_index.sv
module bsu_core_index #(
  parameter int CORE_ID_W = 8,
  parameter int NUM_CORES = 8,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic [CORE_ID_W-1:0] core_id,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_CORES-1:0] onehot
);
  localparam logic [CORE_ID_W-1:0] NC_V = CORE_ID_W'(NUM_CORES);

  logic [CORE_ID_W-1:0] rem;

  always_comb begin
    rem = core_id % NC_V;
    idx = IDX_W'(rem);
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
    assign onehot[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bsu_popcount.sv
module bsu_popcount #(
  parameter int W     = 8,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + OUT_W'(vec[i]);
  end
endmodule

// File: rtl/bsu_mask_bank.sv
module bsu_mask_bank #(
  parameter int NUM_BARRIERS = 4,
  parameter int NUM_CORES    = 8,
  parameter int BAR_W        = $clog2(NUM_BARRIERS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [BAR_W-1:0]                    wr_bar,
  input  logic [NUM_CORES-1:0]                wr_data,
  output logic [NUM_BARRIERS-1:0][NUM_CORES-1:0] masks
);
  for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_bar
    logic                 en;
    logic [NUM_CORES-1:0] mask_q;

    assign en = wr_en && (wr_bar == BAR_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '0;
      else if (en) mask_q <= wr_data;
    end

    assign masks[b] = mask_q;
  end
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit #(
  parameter int NUM_SOCKETS      = 2,
  parameter int CORES_PER_SOCKET = 4,
  parameter int NUM_BARRIERS     = 4,
  parameter int CORE_ID_W        = 8,
  localparam int NUM_CORES       = NUM_SOCKETS * CORES_PER_SOCKET,
  localparam int BAR_W           = $clog2(NUM_BARRIERS),
  localparam int CNT_W           = bsu_pkg::cnt_width(NUM_CORES),
  localparam int IDX_W           = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arr_valid,
  output logic                 arr_ready,
  input  logic [BAR_W-1:0]     arr_bar_id,
  input  logic [CNT_W-1:0]     arr_count,
  input  logic [CORE_ID_W-1:0] arr_core_id,
  output logic [NUM_CORES-1:0] resume_o,
  output logic                 arr_err
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_CORES);

  logic                                  rst_int_n;
  logic [IDX_W-1:0]                      core_idx;
  logic [NUM_CORES-1:0]                  core_bit;
  logic [NUM_BARRIERS-1:0][NUM_CORES-1:0] masks;
  logic [NUM_CORES-1:0]                  merged;
  logic [CNT_W-1:0]                      ones;
  logic                                  accept, bar_ok, count_ok, release_now;
  logic                                  wr_en;
  logic [NUM_CORES-1:0]                  wr_data;
  logic [NUM_CORES-1:0]                  resume_d, resume_q;
  logic                                  err_d, err_q, ready_q;

  bsu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  bsu_core_index #(.CORE_ID_W(CORE_ID_W), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_idx (
    .core_id(arr_core_id), .idx(core_idx), .onehot(core_bit)
  );

  bsu_mask_bank #(.NUM_BARRIERS(NUM_BARRIERS), .NUM_CORES(NUM_CORES), .BAR_W(BAR_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_bar(arr_bar_id),
    .wr_data(wr_data), .masks(masks)
  );

  bsu_popcount #(.W(NUM_CORES), .OUT_W(CNT_W)) u_pop (.vec(merged), .ones(ones));

  // next-state logic
  always_comb begin
    accept      = arr_valid && ready_q;
    bar_ok      = (32'(arr_bar_id) < NUM_BARRIERS);
    count_ok    = (arr_count != '0) && (arr_count <= MAX_CNT);
    merged      = (bar_ok ? masks[arr_bar_id] : '0) | core_bit;
    release_now = accept && bar_ok && count_ok && (ones == arr_count);
    wr_en       = accept && bar_ok;
    wr_data     = release_now ? '0 : merged;
    resume_d    = release_now ? merged : '0;
    err_d       = accept && !(count_ok && bar_ok);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      resume_q <= '0;
      err_q    <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      resume_q <= resume_d;
      err_q    <= err_d;
      ready_q  <= 1'b1;
    end
  end

  assign arr_ready = ready_q;
  assign resume_o  = resume_q;
  assign arr_err   = err_q;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int NUM_CORES = 8,
  parameter int BAR_W     = 2,
  parameter int CNT_W     = 4,
  parameter int CORE_ID_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arr_valid,
  input logic                 arr_ready,
  input logic [BAR_W-1:0]     arr_bar_id,
  input logic [CNT_W-1:0]     arr_count,
  input logic [CORE_ID_W-1:0] arr_core_id,
  input logic [NUM_CORES-1:0] resume_o,
  input logic                 arr_err
);
  logic                 acc;
  logic                 bad_cnt;
  logic [NUM_CORES-1:0] own_bit;

  assign acc     = arr_valid && arr_ready;
  assign bad_cnt = (arr_count == '0) || (32'(arr_count) > NUM_CORES);
  assign own_bit = NUM_CORES'(1) << (32'(arr_core_id) % NUM_CORES);

  // R4: a resume follows an accepted arrival
  assert_resume_after_arrival_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o != '0) |-> $past(acc));

  // R4: the resume holds as many cores as the count requested
  assert_resume_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o != '0) |-> ($countones(resume_o) == 32'($past(arr_count))));

  // R2: the arriving core is among those resumed
  assert_resume_has_arriver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_o != '0) |-> ((resume_o & $past(own_bit)) != '0));

  // R9: an error only follows an unreachable count
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_err |-> $past(acc && bad_cnt));

  // R9: an error never comes with a resume
  assert_err_no_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_err |-> (resume_o == '0));

  // R10: ready stays high once it has risen
  assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arr_ready) |-> arr_ready);
endmodule

bind barrier_sync_unit bsu_checker #(
  .NUM_CORES(NUM_CORES), .BAR_W(BAR_W), .CNT_W(CNT_W), .CORE_ID_W(CORE_ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_ready(arr_ready),
  .arr_bar_id(arr_bar_id), .arr_count(arr_count), .arr_core_id(arr_core_id),
  .resume_o(resume_o), .arr_err(arr_err)
);

// File: tb/sim_barrier_sync_unit.sv
`timescale 1ns/1ps
module sim_barrier_sync_unit;
  logic       clk, rst_n, arr_valid, arr_ready, arr_err;
  logic [1:0] arr_bar_id;
  logic [3:0] arr_count;
  logic [7:0] arr_core_id;
  logic [7:0] resume_o;
  int checks = 0, errors = 0;
  bit done = 0;

  barrier_sync_unit u0 (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_bar_id(arr_bar_id), .arr_count(arr_count), .arr_core_id(arr_core_id),
    .resume_o(resume_o), .arr_err(arr_err)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one arrival; on return, outputs show the cycle after acceptance
  task automatic arrive(input logic [1:0] bar, input logic [3:0] cnt, input logic [7:0] id);
    @(negedge clk);
    arr_valid = 1; arr_bar_id = bar; arr_count = cnt; arr_core_id = id;
    @(negedge clk);
    arr_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 resume after reset", resume_o, 0);
    check("R1 err after reset", arr_err, 0);
    check("R10 ready after reset", arr_ready, 1);
  endtask

  task automatic t_single();
    arrive(0, 1, 3);
    check("R1 R4 single core release", resume_o, 8'h08);
    @(negedge clk);
    check("R11 resume is a pulse", resume_o, 0);
  endtask

  task automatic t_gather();
    arrive(1, 3, 0);
    check("R3 first of three", resume_o, 0);
    arrive(1, 3, 5);
    check("R3 second of three", resume_o, 0);
    arrive(1, 3, 6);
    check("R4 release of three", resume_o, 8'h61);
    check("R5 socket1 core1 is bit5", resume_o[1*4+1], 1);
    @(negedge clk);
  endtask

  task automatic t_modulo();
    arrive(2, 2, 9);
    check("R2 id 9 waits", resume_o, 0);
    arrive(2, 2, 2);
    check("R2 id 9 maps to bit1", resume_o, 8'h06);
    @(negedge clk);
  endtask

  task automatic t_dup();
    arrive(3, 2, 4);
    arrive(3, 2, 4);
    check("R8 duplicate does not release", resume_o, 0);
    arrive(3, 2, 7);
    check("R8 release after second core", resume_o, 8'h90);
    @(negedge clk);
  endtask

  task automatic t_reuse();
    arrive(1, 1, 0);
    check("R6 cleared barrier reused", resume_o, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_indep();
    arrive(0, 2, 1);
    arrive(2, 2, 3);
    check("R7 no cross release", resume_o, 0);
    arrive(0, 2, 2);
    check("R7 barrier0 only its cores", resume_o, 8'h06);
    arrive(2, 2, 5);
    check("R7 barrier2 only its cores", resume_o, 8'h28);
    @(negedge clk);
  endtask

  task automatic t_bad();
    arrive(1, 0, 0);
    check("R9 err on zero count", arr_err, 1);
    check("R9 no release on zero count", resume_o, 0);
    arrive(1, 9, 1);
    check("R9 err on count above cores", arr_err, 1);
    check("R9 no release on large count", resume_o, 0);
    arrive(1, 2, 1);
    check("R9 bits kept, release with valid count", resume_o, 8'h03);
    check("R9 no err on valid count", arr_err, 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; arr_valid = 0; arr_bar_id = 0; arr_count = 0; arr_core_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_gather();
    t_modulo();
    t_dup();
    t_reuse();
    t_indep();
    t_bad();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule